// File: doc/BRIEF.md
# Multi-Region Sector Locator with Erase-Pending Map

This block turns a byte offset into flash-array coordinates: which sector the offset falls in, how long that sector is, and where it starts. The array is laid out as up to four consecutive erase regions. Each region has its own sector count and its own power-of-two sector length, so boot-block layouts with small sectors next to large ones resolve correctly. The incoming offset is first reduced modulo the chip length, so the array image repeats across the wider address space. If the first region's count parameter is zero, the layout falls back to one uniform region described by a separate count/length pair.

Next to the locator sits a bitmap with one bit per sector that records which sectors have an erase queued. An erase-queue strobe marks the sector that holds its address. An erase-done strobe wipes the whole map. Every lookup also reports whether the addressed sector is currently marked. A command sequencer uses this to answer reads from an erasing sector with status rather than data. Lookups take one register stage. An offset that lands past the last region, but still inside the chip length, is reported as an error and not given a sector.

Top module: `sector_locator`

## Requirements
- R1: After reset `res_valid` is 0 and the erase map is empty, so the first lookup of any sector reports `res_erasing` = 0.
- R2: Only the low `CHIP_AW` bits of an address are used. Two addresses that differ only above that bit give identical results.
- R3: For an offset inside region i, `res_sector` equals the sum of the sector counts of regions 0..i-1 plus (offset − region i start) divided by the region i sector length. Regions are packed in index order starting at offset 0.
- R4: `res_len` gives the sector length in bytes. `res_base` gives the offset rounded down to a multiple of that length.
- R5: An offset at or beyond the end of the last populated region gives `res_err` = 1, with `res_sector`, `res_len`, `res_base` and `res_erasing` all 0.
- R6: `res_valid` is `lk_valid` delayed by exactly one clock. The result fields belong to the lookup address presented in that earlier cycle.
- R7: A clock with `er_set` = 1 and `er_clear` = 0 marks the sector that holds `er_addr`. Later lookups anywhere in that sector report `res_erasing` = 1, and lookups in unmarked sectors report 0.
- R8: `er_clear` = 1 empties the map. It wins over an `er_set` in the same clock.
- R9: An `er_set` whose address falls beyond the last region leaves the map unchanged.
- R10: `res_erasing` reflects the map as it stood before any update made in the same clock as the lookup.
- R11: With `N0` = 0, the layout is one region of `UNI_N` sectors, each 2^`UNI_L` bytes long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| er_set | input | 1 | Queue an erase for the sector holding `er_addr` |
| er_addr | input | ADDR_W | Address whose sector is marked |
| er_clear | input | 1 | Erase finished; empty the map |
| res_valid | output | 1 | Result valid, one clock after `lk_valid` |
| res_err | output | 1 | Offset lies beyond the last region |
| res_erasing | output | 1 | Addressed sector is marked in the map |
| res_sector | output | SEC_W | Global sector number |
| res_len | output | CHIP_AW+1 | Sector length in bytes |
| res_base | output | CHIP_AW | Sector start offset |

## Verification
The assertions assume the parameters describe a legal layout. That means power-of-two sector lengths of at least 256 bytes, each region starting on a multiple of its own sector length, and a layout that fits within 2^`CHIP_AW` bytes. The default parameters and the uniform variant in the bench both meet these conditions. The bench does not vary the layout at run time. Lookups are driven into every region, into the gap past the last region, and above the chip-length bit. Erase strobes are driven with and without a same-clock clear, which keeps the map within the set and clear patterns the properties describe.

// File: rtl/sector_locator.sv
module sector_locator #(
  parameter int ADDR_W  = 16,
  parameter int CHIP_AW = 13,
  parameter int N0 = 2,  parameter int L0 = 8,
  parameter int N1 = 1,  parameter int L1 = 9,
  parameter int N2 = 3,  parameter int L2 = 10,
  parameter int N3 = 0,  parameter int L3 = 8,
  parameter int UNI_N = 16,
  parameter int UNI_L = 8,
  localparam bit UNI  = (N0 == 0),
  localparam int EN0 = UNI ? UNI_N : N0,
  localparam int EN1 = UNI ? 0 : N1,
  localparam int EN2 = UNI ? 0 : N2,
  localparam int EN3 = UNI ? 0 : N3,
  localparam int TOTAL = EN0 + EN1 + EN2 + EN3,
  localparam int SEC_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic               er_set,
  input  logic [ADDR_W-1:0]  er_addr,
  input  logic               er_clear,
  output logic               res_valid,
  output logic               res_err,
  output logic               res_erasing,
  output logic [SEC_W-1:0]   res_sector,
  output logic [CHIP_AW:0]   res_len,
  output logic [CHIP_AW-1:0] res_base
);

  localparam int unsigned EL0 = UNI ? UNI_L : L0;
  localparam int unsigned EL1 = L1;
  localparam int unsigned EL2 = L2;
  localparam int unsigned EL3 = L3;
  localparam int unsigned SZ0 = EN0 << EL0;
  localparam int unsigned SZ1 = EN1 << EL1;
  localparam int unsigned SZ2 = EN2 << EL2;
  localparam int unsigned SZ3 = EN3 << EL3;
  localparam int unsigned BASE [4] = '{0, SZ0, SZ0 + SZ1, SZ0 + SZ1 + SZ2};
  localparam int unsigned SIZE [4] = '{SZ0, SZ1, SZ2, SZ3};
  localparam int unsigned LOGL [4] = '{EL0, EL1, EL2, EL3};
  localparam int unsigned FIRST[4] = '{0, EN0, EN0 + EN1, EN0 + EN1 + EN2};

  typedef struct packed {
    logic               hit;
    logic [SEC_W-1:0]   sec;
    logic [CHIP_AW:0]   len;
    logic [CHIP_AW-1:0] base;
  } loc_t;

  function automatic loc_t locate(input logic [ADDR_W-1:0] a);
    loc_t        r;
    int unsigned off;
    r   = '0;
    off = 32'(a[CHIP_AW-1:0]);
    for (int i = 0; i < 4; i++) begin
      if (off >= BASE[i] && off < BASE[i] + SIZE[i]) begin
        r.hit  = 1'b1;
        r.sec  = SEC_W'(FIRST[i] + ((off - BASE[i]) >> LOGL[i]));
        r.len  = (CHIP_AW+1)'(32'd1 << LOGL[i]);
        r.base = CHIP_AW'(off & ~((32'd1 << LOGL[i]) - 32'd1));
      end
    end
    return r;
  endfunction

  loc_t             lk_loc, er_loc;
  logic [TOTAL-1:0] emap;

  assign lk_loc = locate(lk_addr);
  assign er_loc = locate(er_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)                   emap <= '0;
    else if (er_clear)            emap <= '0;
    else if (er_set && er_loc.hit) emap[er_loc.sec] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_err     <= 1'b0;
      res_erasing <= 1'b0;
      res_sector  <= '0;
      res_len     <= '0;
      res_base    <= '0;
    end else begin
      res_valid   <= lk_valid;
      res_err     <= !lk_loc.hit;
      res_erasing <= lk_loc.hit && emap[lk_loc.sec];
      res_sector  <= lk_loc.sec;
      res_len     <= lk_loc.len;
      res_base    <= lk_loc.base;
    end
  end

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r5_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (!res_erasing && res_len == '0 && res_base == '0));
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (({1'b0, res_base} & (res_len - 1'b1)) == '0));
  a_r3_sector_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (32'(res_sector) < TOTAL));
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    er_clear |=> (emap == '0));
  a_r7_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (er_set && !er_clear && er_loc.hit) |=> emap[$past(er_loc.sec)]);

endmodule

// File: tb/sector_locator_test.sv
module sector_locator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_addr = '0;
  logic        er_set = 1'b0;
  logic [15:0] er_addr = '0;
  logic        er_clear = 1'b0;
  logic        res_valid, res_err, res_erasing;
  logic [2:0]  res_sector;
  logic [13:0] res_len;
  logic [12:0] res_base;

  logic        u_valid = 1'b0;
  logic [15:0] u_addr = '0;
  logic        u_rvalid, u_err, u_eras;
  logic [2:0]  u_sec;
  logic [11:0] u_len;
  logic [10:0] u_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_locator uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .er_set(er_set), .er_addr(er_addr), .er_clear(er_clear),
    .res_valid(res_valid), .res_err(res_err), .res_erasing(res_erasing),
    .res_sector(res_sector), .res_len(res_len), .res_base(res_base));

  sector_locator #(.CHIP_AW(11), .N0(0), .UNI_N(8), .UNI_L(8)) uut_uni (
    .clk(clk), .rst_n(rst_n), .lk_valid(u_valid), .lk_addr(u_addr),
    .er_set(1'b0), .er_addr(16'h0), .er_clear(1'b0),
    .res_valid(u_rvalid), .res_err(u_err), .res_erasing(u_eras),
    .res_sector(u_sec), .res_len(u_len), .res_base(u_base));

  // Behavioural layout walk; cfg 0 = default layout, cfg 1 = uniform layout
  task automatic model(input int cfg, input int addr,
                       output int sec, output int len, output int base, output int err);
    int n[4], l[4], aw, off, start, first;
    if (cfg == 0) begin n = '{2, 1, 3, 0}; l = '{8, 9, 10, 8}; aw = 13; end
    else          begin n = '{8, 0, 0, 0}; l = '{8, 8, 8, 8};  aw = 11; end
    off = addr % (1 << aw);
    start = 0; first = 0;
    sec = 0; len = 0; base = 0; err = 1;
    for (int i = 0; i < 4; i++) begin
      if (err == 1 && n[i] != 0) begin
        if (off < start + n[i] * (1 << l[i])) begin
          err  = 0;
          sec  = first + (off - start) / (1 << l[i]);
          len  = 1 << l[i];
          base = off - (off % (1 << l[i]));
        end
        start += n[i] * (1 << l[i]);
        first += n[i];
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, stepped on every clock
  bit mmap[64];
  int e_valid = 0, e_sec = 0, e_len = 0, e_base = 0, e_err = 0, e_eras = 0;

  always @(posedge clk) begin
    int s, ln, b, er;
    if (!rst_n) begin
      e_valid = 0; e_sec = 0; e_len = 0; e_base = 0; e_err = 0; e_eras = 0;
      foreach (mmap[i]) mmap[i] = 1'b0;
    end else begin
      model(0, int'(lk_addr), s, ln, b, er);
      e_valid = int'(lk_valid);
      e_sec = s; e_len = ln; e_base = b; e_err = er;
      e_eras = (er == 0 && mmap[s]) ? 1 : 0;
      if (er_clear) foreach (mmap[i]) mmap[i] = 1'b0;
      else if (er_set) begin
        model(0, int'(er_addr), s, ln, b, er);
        if (er == 0) mmap[s] = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(res_valid) == e_valid, "R6 valid", int'(res_valid), e_valid);
      if (e_valid == 1) begin
        chk(int'(res_err) == e_err, "R5 err", int'(res_err), e_err);
        chk(int'(res_sector) == e_sec, "R3 sector", int'(res_sector), e_sec);
        chk(int'(res_len) == e_len, "R4 len", int'(res_len), e_len);
        chk(int'(res_base) == e_base, "R4 base", int'(res_base), e_base);
        chk(int'(res_erasing) == e_eras, "R7 erasing", int'(res_erasing), e_eras);
      end
    end
  end

  // Drive one clock of stimulus; on return the registered result is visible
  task automatic step(input bit lv, input int la, input bit es, input int ea, input bit ec);
    lk_valid = lv; lk_addr = 16'(la);
    er_set = es; er_addr = 16'(ea); er_clear = ec;
    @(posedge clk); #1;
    lk_valid = 1'b0; er_set = 1'b0; er_clear = 1'b0;
  endtask

  task automatic ulook(input int a);
    int s, ln, b, er;
    u_valid = 1'b1; u_addr = 16'(a);
    @(posedge clk); #1;
    u_valid = 1'b0;
    model(1, a, s, ln, b, er);
    chk(int'(u_sec) == s && int'(u_err) == er, "R11 uniform sector", int'(u_sec), s);
    chk(int'(u_len) == ln && int'(u_base) == b, "R11 uniform base", int'(u_base), b);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    #1;
    chk(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);
    rst_n = 1'b1;
    // R1: empty map right after reset
    step(1, 16'h0000, 0, 0, 0);
    chk(res_erasing == 1'b0, "R1 empty map", int'(res_erasing), 0);
    // R3/R4 sweep through every region and the gap
    for (int a = 0; a < 8192; a += 160) step(1, a, 0, 0, 0);
    step(1, 16'h0123, 0, 0, 0);
    chk(res_sector == 3'd1 && res_base == 13'h100, "R3 region0", int'(res_sector), 1);
    step(1, 16'h0300, 0, 0, 0);
    chk(res_sector == 3'd2 && res_len == 14'd512, "R4 region1", int'(res_len), 512);
    // R2: wrap above the chip-length bit
    step(1, 16'h0BFF, 0, 0, 0);
    s0 = int'(res_sector);
    step(1, 16'h2BFF, 0, 0, 0);
    chk(int'(res_sector) == s0 && s0 == 4, "R2 wrap", int'(res_sector), 4);
    // R5: beyond last region, also via masked high bits
    step(1, 16'h1000, 0, 0, 0);
    chk(res_err == 1'b1, "R5 gap", int'(res_err), 1);
    step(1, 16'hF000, 0, 0, 0);
    chk(res_err == 1'b1 && res_sector == 3'd0, "R5 wrapped gap", int'(res_err), 1);
    // R7 and R10: lookup in the same clock as the set sees the old map
    step(1, 16'h0900, 1, 16'h0A10, 0);
    chk(res_erasing == 1'b0, "R10 same-clock set", int'(res_erasing), 0);
    step(1, 16'h0BFC, 0, 0, 0);
    chk(res_erasing == 1'b1, "R7 marked sector", int'(res_erasing), 1);
    step(1, 16'h0C00, 0, 0, 0);
    chk(res_erasing == 1'b0, "R7 neighbour clear", int'(res_erasing), 0);
    // R8: clear empties the map
    step(0, 0, 1, 16'h0010, 0);
    step(0, 0, 0, 0, 1);
    step(1, 16'h0010, 0, 0, 0);
    chk(res_erasing == 1'b0, "R8 clear", int'(res_erasing), 0);
    // R8: clear wins over a set in the same clock
    step(0, 0, 1, 16'h0110, 1);
    step(1, 16'h0110, 0, 0, 0);
    chk(res_erasing == 1'b0, "R8 clear priority", int'(res_erasing), 0);
    // R9: out-of-range set leaves every sector unmarked
    step(0, 0, 1, 16'h1800, 0);
    for (int a = 0; a < 4096; a += 256) begin
      step(1, a, 0, 0, 0);
      chk(res_erasing == 1'b0, "R9 no mark", int'(res_erasing), 0);
    end
    // Multiple marks accumulate, then one clear
    step(0, 0, 1, 16'h0000, 0);
    step(0, 0, 1, 16'h0FFF, 0);
    for (int a = 0; a < 4096; a += 128) step(1, a, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    for (int a = 0; a < 4096; a += 512) step(1, a, 0, 0, 0);
    // R11: uniform fallback layout
    ulook(16'h0345);
    ulook(16'h0845);
    ulook(16'h07FF);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule